// File: doc/BRIEF.md
# I/O Translation Unit Control and Status Register File

This block is the software-visible register file that sits beside an I/O address translation unit. A processor reaches it over a simple word-wide request port: one valid strobe, a write flag, a byte offset and write data, with read data returned on the clock after the request. Each register has its own rule for what a write may change. Some keep only selected bits. Some always set fixed bits. One can only gain bits, never lose them. The rest keep the whole word.

The register file also feeds the translation unit. It supplies the enable bit and the page-table base. It decodes a 3-bit range code into the lowest address of the translated window, and that window always ends at the top of the 32-bit space. When the translation unit reports a fault, one strobe loads the fault status and fault address registers and raises a level interrupt. Software clears the interrupt by reading or writing either of those two registers. The flush registers and the arbitration and per-slot configuration words only store their bits here.

Top module: `iotu_csr`

## Requirements
- R1: After reset the registers hold these values: control 0x41000000 (implementation/version byte 0x41 in bits 31:24), fault status 0x00800000, arbiter enable 0x00000003, arbitration enable 0x00000008 and mask ID 0x23000000. Every other register is 0. The interrupt and the enable output are low, and the window start reads 0xFF000000.
- R2: A write to control (offset 0x0000) keeps only bits 0x0000001D and reads back with the version byte in bits 31:24. The enable output follows control bit 0.
- R3: The window start output equals the complement of ((1 << (24 + code)) - 1), where code is control bits 4:2. Code 0 gives 0xFF000000 and code 7 gives 0x80000000.
- R4: A table base write (offset 0x0004) keeps only bits 0x07FFFC00, and the stored value appears on the table base output. A write to any of the four slot-config words (offsets 0x1010, 0x1014, 0x1018, 0x101C) keeps only bits 0x00010003.
- R5: An arbiter enable write (offset 0x1008) keeps bits 0x801F000F and always sets bit 0.
- R6: A fault status write (offset 0x1000) keeps bits 0xFF0FFFFF and always sets bit 23. A fault address write (offset 0x1004) stores the whole word.
- R7: An arbitration enable write (offset 0x2000) keeps bits 0x001F0000 and always sets bit 3.
- R8: A mask ID write (offset 0x3018) ORs the low 24 bits of the data into the register and never clears a bit.
- R9: The full flush (0x0014) and page flush (0x0018) registers store the whole written word. A write to an unmapped offset, or to an offset whose bits 1:0 are not zero, changes no register. A read from either kind of offset returns 0.
- R10: A fault-capture strobe loads fault status with (status input AND 0xFF0FFFFF) OR 0x00800000, loads fault address with the address input, and sets the interrupt on the same edge.
- R11: A read or a write of fault status or fault address clears the interrupt on the edge where the request is presented. An access to any other register leaves the interrupt unchanged.
- R12: When a capture strobe and a software access to the fault registers fall in the same cycle, the capture wins: the interrupt is set and the captured values are stored.
- R13: Read data appears on the read data output on the clock edge that follows the read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_ofs | input | 14 | Byte offset of the register |
| req_wdata | input | 32 | Write data |
| req_rdata | output | 32 | Read data, registered |
| flt_capture | input | 1 | Fault-capture strobe from the translation unit |
| flt_status | input | 32 | Fault status word to capture |
| flt_addr | input | 32 | Faulting address to capture |
| irq | output | 1 | Level fault interrupt |
| xlat_enable | output | 1 | Translation enable (control bit 0) |
| win_start | output | 32 | Lowest address of the translated window |
| table_base | output | 32 | Page-table base register value |

## Verification
Each register is written with all ones and then with a sparse or zero pattern. All ones exposes a wrong keep-mask. The sparse or zero pattern exposes a missing forced bit and any bit that is stored when it should be dropped. All eight range codes are stepped through and the window start is compared with the shift formula, which separates an off-by-one in the code from a wrong base size. The mask ID is written with disjoint and then zero-low patterns to show that it only accumulates bits. Capture is tested alone, followed by reads, writes and accesses to an unrelated register. It is also presented in the same cycle as a fault-register read and as a fault-register write, which tells a capture-wins ordering from a clear-wins ordering.

// File: rtl/iotu_csr_pkg.sv
package iotu_csr_pkg;

   localparam int OFS_W  = 14;
   localparam int DATA_W = 32;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_CTRL,
      SEL_BASE,
      SEL_TFL,
      SEL_PFL,
      SEL_FSR,
      SEL_FAR,
      SEL_AER,
      SEL_SLOT,
      SEL_ARB,
      SEL_MID
   } csr_sel_e;

   localparam logic [OFS_W-1:0] OFS_CTRL  = 14'h0000;
   localparam logic [OFS_W-1:0] OFS_BASE  = 14'h0004;
   localparam logic [OFS_W-1:0] OFS_TFL   = 14'h0014;
   localparam logic [OFS_W-1:0] OFS_PFL   = 14'h0018;
   localparam logic [OFS_W-1:0] OFS_FSR   = 14'h1000;
   localparam logic [OFS_W-1:0] OFS_FAR   = 14'h1004;
   localparam logic [OFS_W-1:0] OFS_AER   = 14'h1008;
   localparam logic [OFS_W-1:0] OFS_SLOT0 = 14'h1010;
   localparam logic [OFS_W-1:0] OFS_ARB   = 14'h2000;
   localparam logic [OFS_W-1:0] OFS_MID   = 14'h3018;

   localparam logic [DATA_W-1:0] CTRL_KEEP  = 32'h0000_001D;
   localparam logic [DATA_W-1:0] BASE_KEEP  = 32'h07FF_FC00;
   localparam logic [DATA_W-1:0] SLOT_KEEP  = 32'h0001_0003;
   localparam logic [DATA_W-1:0] AER_KEEP   = 32'h801F_000F;
   localparam logic [DATA_W-1:0] AER_FORCE  = 32'h0000_0001;
   localparam logic [DATA_W-1:0] AER_RST    = 32'h0000_0003;
   localparam logic [DATA_W-1:0] FSR_KEEP   = 32'hFF0F_FFFF;
   localparam logic [DATA_W-1:0] FSR_FORCE  = 32'h0080_0000;
   localparam logic [DATA_W-1:0] ARB_KEEP   = 32'h001F_0000;
   localparam logic [DATA_W-1:0] ARB_FORCE  = 32'h0000_0008;
   localparam logic [DATA_W-1:0] MID_KEEP   = 32'h00FF_FFFF;
   localparam logic [DATA_W-1:0] MID_RST    = 32'h2300_0000;

endpackage

// File: rtl/iotu_csr_decode.sv
module iotu_csr_decode
   import iotu_csr_pkg::*;
#(
   parameter int NUM_SLOTS = 4
) (
   input  logic [OFS_W-1:0] ofs_i,
   output csr_sel_e         sel_o,
   output logic [1:0]       slot_o
);

   localparam logic [OFS_W-5:0] SLOT_ROW = OFS_SLOT0[OFS_W-1:4];

   if (NUM_SLOTS < 1 || NUM_SLOTS > 4) begin : g_bad_slots
      $error("iotu_csr_decode: NUM_SLOTS must be 1..4");
   end

   always_comb begin
      sel_o  = SEL_NONE;
      slot_o = ofs_i[3:2];
      if (ofs_i[1:0] == 2'b00) begin
         if (ofs_i[OFS_W-1:4] == SLOT_ROW) begin
            if (int'(ofs_i[3:2]) < NUM_SLOTS) sel_o = SEL_SLOT;
         end else begin
            case (ofs_i)
               OFS_CTRL: sel_o = SEL_CTRL;
               OFS_BASE: sel_o = SEL_BASE;
               OFS_TFL:  sel_o = SEL_TFL;
               OFS_PFL:  sel_o = SEL_PFL;
               OFS_FSR:  sel_o = SEL_FSR;
               OFS_FAR:  sel_o = SEL_FAR;
               OFS_AER:  sel_o = SEL_AER;
               OFS_ARB:  sel_o = SEL_ARB;
               OFS_MID:  sel_o = SEL_MID;
               default:  sel_o = SEL_NONE;
            endcase
         end
      end
   end

endmodule

// File: rtl/iotu_csr_window.sv
module iotu_csr_window #(
   parameter int AW       = 32,
   parameter int CODE_W   = 3,
   parameter int MIN_LOG2 = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code_i,
   output logic [AW-1:0]     win_o
);

   localparam int NUM_CODES = 2 ** CODE_W;

   if (MIN_LOG2 + NUM_CODES - 1 >= AW) begin : g_bad_range
      $error("iotu_csr_window: largest window exceeds half the space");
   end

   logic [AW-1:0] cand [NUM_CODES];

   for (genvar k = 0; k < NUM_CODES; k++) begin : g_cand
      assign cand[k] = ~((AW'(1) << (MIN_LOG2 + k)) - AW'(1));
   end

   assign win_o = cand[code_i];

   // R3
   window_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
      win_o[AW-1] && $onehot(~win_o + AW'(1)));

endmodule

// File: rtl/iotu_csr_fault.sv
module iotu_csr_fault
   import iotu_csr_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fsr_i,
   input  logic              wr_far_i,
   input  logic              acc_i,
   input  logic [DATA_W-1:0] wdata_i,
   input  logic              cap_i,
   input  logic [DATA_W-1:0] cap_status_i,
   input  logic [DATA_W-1:0] cap_addr_i,
   output logic [DATA_W-1:0] fsr_o,
   output logic [DATA_W-1:0] far_o,
   output logic              irq_o
);

   logic [DATA_W-1:0] fsr_q;
   logic [DATA_W-1:0] far_q;
   logic              irq_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fsr_q <= FSR_FORCE;
         far_q <= '0;
         irq_q <= 1'b0;
      end else if (cap_i) begin
         fsr_q <= (cap_status_i & FSR_KEEP) | FSR_FORCE;
         far_q <= cap_addr_i;
         irq_q <= 1'b1;
      end else begin
         if (wr_fsr_i) fsr_q <= (wdata_i & FSR_KEEP) | FSR_FORCE;
         if (wr_far_i) far_q <= wdata_i;
         if (acc_i)    irq_q <= 1'b0;
      end
   end

   assign fsr_o = fsr_q;
   assign far_o = far_q;
   assign irq_o = irq_q;

   // R10
   cap_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i |=> irq_o);

   // R10
   cap_loads_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cap_i |=> (far_o == $past(cap_addr_i)));

   // R11
   acc_clears_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_i && !cap_i) |=> !irq_o);

   // R11
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!acc_i && !cap_i) |=> $stable(irq_o));

endmodule

// File: rtl/iotu_csr.sv
module iotu_csr
   import iotu_csr_pkg::*;
#(
   parameter logic [7:0] VERSION   = 8'h41,
   parameter int         NUM_SLOTS = 4,
   parameter int         WIN_CODE  = 3,
   parameter int         WIN_MIN   = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [OFS_W-1:0]  req_ofs,
   input  logic [DATA_W-1:0] req_wdata,
   output logic [DATA_W-1:0] req_rdata,
   input  logic              flt_capture,
   input  logic [DATA_W-1:0] flt_status,
   input  logic [DATA_W-1:0] flt_addr,
   output logic              irq,
   output logic              xlat_enable,
   output logic [DATA_W-1:0] win_start,
   output logic [DATA_W-1:0] table_base
);

   localparam logic [DATA_W-1:0] CTRL_RST = {VERSION, {(DATA_W-8){1'b0}}};
   localparam int CODE_LSB = 2;

   if (CODE_LSB + WIN_CODE > 5) begin : g_bad_code
      $error("iotu_csr: range code must fit in control bits 4:2");
   end

   csr_sel_e   sel;
   logic [1:0] slot_idx;
   logic       wr_en;
   logic       flt_acc;

   logic [DATA_W-1:0] ctrl_q, base_q, tfl_q, pfl_q, aer_q, arb_q, mid_q;
   logic [DATA_W-1:0] slot_q [NUM_SLOTS];
   logic [DATA_W-1:0] fsr_w, far_w;
   logic [DATA_W-1:0] rd_mux, rdata_q;

   iotu_csr_decode #(.NUM_SLOTS(NUM_SLOTS)) u_decode (
      .ofs_i  (req_ofs),
      .sel_o  (sel),
      .slot_o (slot_idx)
   );

   assign wr_en   = req_valid && req_write;
   assign flt_acc = req_valid && (sel == SEL_FSR || sel == SEL_FAR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RST;
         base_q <= '0;
         tfl_q  <= '0;
         pfl_q  <= '0;
         aer_q  <= AER_RST;
         arb_q  <= ARB_FORCE;
         mid_q  <= MID_RST;
      end else if (wr_en) begin
         case (sel)
            SEL_CTRL: ctrl_q <= (req_wdata & CTRL_KEEP) | CTRL_RST;
            SEL_BASE: base_q <= req_wdata & BASE_KEEP;
            SEL_TFL:  tfl_q  <= req_wdata;
            SEL_PFL:  pfl_q  <= req_wdata;
            SEL_AER:  aer_q  <= (req_wdata & AER_KEEP) | AER_FORCE;
            SEL_ARB:  arb_q  <= (req_wdata & ARB_KEEP) | ARB_FORCE;
            SEL_MID:  mid_q  <= mid_q | (req_wdata & MID_KEEP);
            default:  ;
         endcase
      end
   end

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot_q[g] <= '0;
         else if (wr_en && sel == SEL_SLOT && slot_idx == 2'(g))
            slot_q[g] <= req_wdata & SLOT_KEEP;
      end
   end

   iotu_csr_fault u_fault (
      .clk          (clk),
      .rst_n        (rst_n),
      .wr_fsr_i     (wr_en && sel == SEL_FSR),
      .wr_far_i     (wr_en && sel == SEL_FAR),
      .acc_i        (flt_acc),
      .wdata_i      (req_wdata),
      .cap_i        (flt_capture),
      .cap_status_i (flt_status),
      .cap_addr_i   (flt_addr),
      .fsr_o        (fsr_w),
      .far_o        (far_w),
      .irq_o        (irq)
   );

   iotu_csr_window #(
      .AW       (DATA_W),
      .CODE_W   (WIN_CODE),
      .MIN_LOG2 (WIN_MIN)
   ) u_window (
      .clk    (clk),
      .rst_n  (rst_n),
      .code_i (ctrl_q[CODE_LSB +: WIN_CODE]),
      .win_o  (win_start)
   );

   always_comb begin
      case (sel)
         SEL_CTRL: rd_mux = ctrl_q;
         SEL_BASE: rd_mux = base_q;
         SEL_TFL:  rd_mux = tfl_q;
         SEL_PFL:  rd_mux = pfl_q;
         SEL_FSR:  rd_mux = fsr_w;
         SEL_FAR:  rd_mux = far_w;
         SEL_AER:  rd_mux = aer_q;
         SEL_SLOT: rd_mux = slot_q[slot_idx];
         SEL_ARB:  rd_mux = arb_q;
         SEL_MID:  rd_mux = mid_q;
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdata_q <= '0;
      else if (req_valid && !req_write)
         rdata_q <= rd_mux;
   end

   assign req_rdata   = rdata_q;
   assign xlat_enable = ctrl_q[0];
   assign table_base  = base_q;

   // R8
   mid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((mid_q & $past(mid_q)) == $past(mid_q)));

   // R2
   enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel == SEL_CTRL) |=> $stable(xlat_enable));

   // R4
   base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && sel == SEL_BASE) |=> $stable(table_base));

endmodule

// File: tb/iotu_csr_bench.sv
`timescale 1ns/1ps
module iotu_csr_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [13:0] req_ofs = '0;
   logic [31:0] req_wdata = '0;
   logic [31:0] req_rdata;
   logic        flt_capture = 1'b0;
   logic [31:0] flt_status = '0;
   logic [31:0] flt_addr = '0;
   logic        irq, xlat_enable;
   logic [31:0] win_start, table_base;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   iotu_csr u_iotu_csr (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write), .req_ofs(req_ofs),
      .req_wdata(req_wdata), .req_rdata(req_rdata),
      .flt_capture(flt_capture), .flt_status(flt_status), .flt_addr(flt_addr),
      .irq(irq), .xlat_enable(xlat_enable),
      .win_start(win_start), .table_base(table_base)
   );

   localparam int NV = 18;
   localparam logic [77:0] VEC [NV] = '{
      {14'h0000, 32'hFFFF_FFFF, 32'h4100_001D},  // R2
      {14'h0004, 32'hFFFF_FFFF, 32'h07FF_FC00},  // R4
      {14'h0014, 32'hA5A5_1234, 32'hA5A5_1234},  // R9
      {14'h0018, 32'hDEAD_BEEF, 32'hDEAD_BEEF},  // R9
      {14'h1004, 32'h1234_5678, 32'h1234_5678},  // R6
      {14'h1000, 32'hFFFF_FFFF, 32'hFF8F_FFFF},  // R6
      {14'h1000, 32'h0000_0000, 32'h0080_0000},  // R6
      {14'h1008, 32'hFFFF_FFFF, 32'h801F_000F},  // R5
      {14'h1008, 32'h0000_0000, 32'h0000_0001},  // R5
      {14'h1010, 32'hFFFF_FFFF, 32'h0001_0003},  // R4
      {14'h1014, 32'hFFFF_FFFF, 32'h0001_0003},  // R4
      {14'h1018, 32'h0000_0002, 32'h0000_0002},  // R4
      {14'h101C, 32'hFFFE_FFFC, 32'h0000_0000},  // R4
      {14'h2000, 32'hFFFF_FFFF, 32'h001F_0008},  // R7
      {14'h2000, 32'h0000_0000, 32'h0000_0008},  // R7
      {14'h0008, 32'hFFFF_FFFF, 32'h0000_0000},  // R9
      {14'h1020, 32'hFFFF_FFFF, 32'h0000_0000},  // R9
      {14'h3000, 32'hFFFF_FFFF, 32'h0000_0000}   // R9
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [13:0] a, input logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b1; req_ofs = a; req_wdata = d;
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   task automatic rd(input logic [13:0] a, output logic [31:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_ofs = a;
      @(negedge clk);
      req_valid = 1'b0;
      d = req_rdata;
   endtask

   task automatic capture(input logic [31:0] st, input logic [31:0] ad);
      @(negedge clk);
      flt_capture = 1'b1; flt_status = st; flt_addr = ad;
      @(negedge clk);
      flt_capture = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      chk("R1 irq", {31'b0, irq}, 32'h0);
      chk("R1 enable", {31'b0, xlat_enable}, 32'h0);
      chk("R1 window", win_start, 32'hFF00_0000);
      chk("R1 table_base", table_base, 32'h0);
      rd(14'h0000, v); chk("R1 ctrl", v, 32'h4100_0000);
      rd(14'h1000, v); chk("R1 fsr", v, 32'h0080_0000);
      rd(14'h1008, v); chk("R1 aer", v, 32'h0000_0003);
      rd(14'h2000, v); chk("R1 arb", v, 32'h0000_0008);
      rd(14'h3018, v); chk("R1 mid", v, 32'h2300_0000);
      rd(14'h0018, v); chk("R1 pflush", v, 32'h0);
      rd(14'h101C, v); chk("R1 slot3", v, 32'h0);

      // Vector walk: write then read back (R2 R4 R5 R6 R7 R9 R13)
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][77:64], VEC[i][63:32]);
         rd(VEC[i][77:64], v);
         chk($sformatf("R13 vector %0d ofs %h", i, VEC[i][77:64]), v, VEC[i][31:0]);
      end
      chk("R2 enable after ctrl write", {31'b0, xlat_enable}, 32'h1);
      chk("R4 table_base port", table_base, 32'h07FF_FC00);

      // R3 window codes
      for (int c = 0; c < 8; c++) begin
         wr(14'h0000, (32'(c) << 2) | 32'h1);
         chk($sformatf("R3 window code %0d", c), win_start, ~((32'h1 << (24 + c)) - 32'h1));
         chk("R2 enable set", {31'b0, xlat_enable}, 32'h1);
      end
      wr(14'h0000, 32'h0000_0000);
      chk("R2 enable clear", {31'b0, xlat_enable}, 32'h0);
      chk("R3 window code 0 again", win_start, 32'hFF00_0000);

      // R8 mask ID only gains bits
      wr(14'h3018, 32'h0000_00F0); rd(14'h3018, v); chk("R8 mid or 1", v, 32'h2300_00F0);
      wr(14'h3018, 32'h0000_000F); rd(14'h3018, v); chk("R8 mid or 2", v, 32'h2300_00FF);
      wr(14'h3018, 32'hFF00_0000); rd(14'h3018, v); chk("R8 mid high ignored", v, 32'h2300_00FF);

      // R9 misaligned write ignored, misaligned read returns 0
      wr(14'h0004, 32'h0000_0000);
      wr(14'h0005, 32'hFFFF_FFFF);
      rd(14'h0004, v); chk("R9 misaligned write ignored", v, 32'h0);
      chk("R9 table_base unchanged", table_base, 32'h0);
      rd(14'h1001, v); chk("R9 misaligned read zero", v, 32'h0);

      // R10 capture
      capture(32'hABCD_EF12, 32'hFE00_3000);
      chk("R10 irq set", {31'b0, irq}, 32'h1);
      rd(14'h0000, v);
      chk("R11 other access keeps irq", {31'b0, irq}, 32'h1);
      rd(14'h1000, v);
      chk("R10 fsr captured", v, 32'hAB8D_EF12);
      chk("R11 read fsr clears irq", {31'b0, irq}, 32'h0);
      rd(14'h1004, v); chk("R10 far captured", v, 32'hFE00_3000);

      capture(32'h0000_0000, 32'h8000_1000);
      chk("R10 irq set again", {31'b0, irq}, 32'h1);
      wr(14'h1004, 32'h0000_0055);
      chk("R11 write far clears irq", {31'b0, irq}, 32'h0);

      capture(32'h1111_1111, 32'h2222_2222);
      rd(14'h1004, v);
      chk("R11 read far clears irq", {31'b0, irq}, 32'h0);

      // R12 capture wins over simultaneous read
      @(negedge clk);
      flt_capture = 1'b1; flt_status = 32'h4000_0000; flt_addr = 32'hFFF0_0000;
      req_valid = 1'b1; req_write = 1'b0; req_ofs = 14'h1004;
      @(negedge clk);
      flt_capture = 1'b0; req_valid = 1'b0;
      chk("R12 irq wins over read", {31'b0, irq}, 32'h1);

      // R12 capture wins over simultaneous fsr write
      @(negedge clk);
      flt_capture = 1'b1; flt_status = 32'h0F0F_0F0F; flt_addr = 32'hC000_0004;
      req_valid = 1'b1; req_write = 1'b1; req_ofs = 14'h1000; req_wdata = 32'h0;
      @(negedge clk);
      flt_capture = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      chk("R12 irq wins over write", {31'b0, irq}, 32'h1);
      rd(14'h1000, v); chk("R12 fsr holds captured value", v, 32'h0F8F_0F0F);
      rd(14'h1004, v); chk("R12 far holds captured value", v, 32'hC000_0004);

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule